// File: doc/BRIEF.md
# Interleaved-Operand 64-bit Keyed Digest Engine

This engine condenses two 64-bit operands and a 64-bit key into one 64-bit digest. It first arranges the operand bytes into two 64-bit words, called H and L. It then splits them into four 32-bit quarters. Each quarter passes through a small 32-round Feistel permutation. That permutation works on 16-bit halves and uses a key schedule that is expanded from the key. A lane number from 0 to 3 rotates which schedule word each round uses, so every quarter sees a different effective key. The two enciphered 64-bit words are XORed to give the digest. A typical use is to compute a tag over a return address and a stack pointer, to be stored and later compared.

A request is offered with `req_valid`. It is taken in a cycle where `req_ready` is high, and at that point the operands and the key are latched. Two parameters set how the work is laid out. `PARALLEL_LANES` runs all four lanes at once (4) or one lane after another (1). `ROUNDS_PER_CYCLE` sets how many Feistel rounds run in one clock (1, 2 or 4). When the digest is ready, `res_valid` rises. It stays high, with a frozen digest, until `res_ack` is seen. No new request is taken during that time.

Top module: `hdig_digest_unit`

## Requirements
- R1: After reset, req_ready is 1, res_valid is 0 and res_digest is all zeros.
- R2: For i = 0..3, byte 2i of H equals byte 4+i of operand A, and byte 7-2i of H equals byte i of operand B. Byte n means bits 8n+7:8n.
- R3: For i = 0..3, byte 2i of L equals byte i of operand A, and byte 7-2i of L equals byte 4+i of operand B.
- R4: Lane cipher, key schedule. The schedule words are k0 = key[63:48], k1 = key[47:32], k2 = key[31:16] and k3 = key[15:0]. For i = 0..27, k(i+4) = 0xFFFC ^ z_i ^ k_i ^ t ^ ror1(t), where t = ror3(k(i+3)) ^ k(i+1) and z_i is bit 63-i of 0xFA2561CDF44AC398.
- R5: Lane cipher, rounds. The 32-bit input is split into lo = bits 15:0 and hi = bits 31:16. Round j (0..31) uses key word k[4*floor(j/4) + ((j + lane) mod 4)]. Each round computes f = (rol1(lo) & rol8(lo)) ^ rol2(lo), then sets new lo = hi ^ f ^ keyword and new hi = old lo. The output is {hi, lo}.
- R6: Lane assignment. H[63:32] goes through lane 0, H[31:0] through lane 1, L[63:32] through lane 2 and L[31:0] through lane 3. The digest is {lane0 ^ lane2, lane1 ^ lane3}.
- R7: A request is accepted only in a cycle with req_valid and req_ready both high. req_ready is low from the cycle after acceptance until the result has been acknowledged.
- R8: While res_valid is high and res_ack is low, res_valid stays high and res_digest does not change. A req_valid asserted during that time is not accepted.
- R9: Operands A, B and the key are sampled at acceptance. Later changes on req_a, req_b or req_key do not affect the digest in progress.
- R10: res_valid rises exactly (32 / ROUNDS_PER_CYCLE) * (4 / PARALLEL_LANES) clock edges after the accepting edge.
- R11: In the cycle after res_ack is taken with res_valid high, res_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Engine idle and able to accept |
| req_a | input | 64 | Operand A |
| req_b | input | 64 | Operand B |
| req_key | input | 64 | Cipher key |
| res_valid | output | 1 | Digest available |
| res_ack | input | 1 | Consumer takes the digest |
| res_digest | output | 64 | Digest value |

## Verification
The hardest case to reach is a new request that waits while the previous result is still unacknowledged. The stimulus holds `res_ack` low for many cycles and asserts `req_valid` with different operands during that time. It then checks that the digest stays frozen and that `req_ready` stays low. It acknowledges with `req_valid` still high, so the waiting request is accepted on the very next edge, and its digest is compared with a model. Every request also scrambles its operand and key inputs right after acceptance, which shows that the latching works. Operands with one live byte expose the interleave mapping byte by byte.

// File: rtl/hdig_pkg.sv
package hdig_pkg;

   localparam int unsigned HALF_W     = 16;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned OPND_W     = 64;
   localparam int unsigned NUM_ROUNDS = 32;
   localparam int unsigned NUM_LANES  = 4;
   localparam int unsigned KEY_WORDS  = 4;
   localparam int unsigned NUM_GROUPS = NUM_ROUNDS / KEY_WORDS;
   localparam int unsigned GRP_W      = $clog2(NUM_GROUPS);

   localparam logic [HALF_W-1:0] SCHED_CONST = 16'hFFFC;
   localparam logic [OPND_W-1:0] SCHED_SEQ   = 64'hFA2561CDF44AC398;

   typedef logic [HALF_W-1:0] half_t;
   typedef logic [WORD_W-1:0] word_t;
   // element 0 is the lowest-numbered schedule word of the current group
   typedef half_t [KEY_WORDS-1:0] kwin_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } state_t;

   function automatic half_t rotl(input half_t v, input int unsigned n);
      half_t r;
      r = half_t'((v << n) | (v >> (HALF_W - n)));
      return r;
   endfunction

   function automatic half_t rotr(input half_t v, input int unsigned n);
      return rotl(v, HALF_W - n);
   endfunction

   // Feistel mixing function on the left half
   function automatic half_t mix_f(input half_t x);
      return (rotl(x, 1) & rotl(x, 8)) ^ rotl(x, 2);
   endfunction

   // one schedule expansion step
   function automatic half_t sched_step(input half_t a, input half_t b,
                                        input half_t d, input logic zb);
      half_t t;
      t = rotr(d, 3) ^ b;
      return SCHED_CONST ^ {{(HALF_W-1){1'b0}}, zb} ^ a ^ t ^ rotr(t, 1);
   endfunction

   // expand the next four schedule words from the current group window
   function automatic kwin_t kwin_next(input kwin_t w, input logic [GRP_W-1:0] g);
      kwin_t n;
      logic [5:0] base;
      base = {g, 2'b00};
      n[0] = sched_step(w[0], w[1], w[3], SCHED_SEQ[6'd63 - base]);
      n[1] = sched_step(w[1], w[2], n[0], SCHED_SEQ[6'd62 - base]);
      n[2] = sched_step(w[2], w[3], n[1], SCHED_SEQ[6'd61 - base]);
      n[3] = sched_step(w[3], n[0], n[2], SCHED_SEQ[6'd60 - base]);
      return n;
   endfunction

endpackage

// File: rtl/hdig_byte_interleave.sv
module hdig_byte_interleave
   import hdig_pkg::*;
#(
   parameter int unsigned BYTES = 8
)(
   input  logic [BYTES*8-1:0] opnd_a,
   input  logic [BYTES*8-1:0] opnd_b,
   output logic [BYTES*8-1:0] hi_word,
   output logic [BYTES*8-1:0] lo_word
);
   localparam int unsigned HALF_BYTES = BYTES / 2;

   if (BYTES != OPND_W / 8) begin : g_bad_bytes
      $error("hdig_byte_interleave: BYTES must match the operand width");
   end

   for (genvar i = 0; i < HALF_BYTES; i++) begin : g_pair
      // even slots take A bytes, mirrored odd slots take B bytes
      assign hi_word[8*(2*i) +: 8]         = opnd_a[8*(HALF_BYTES+i) +: 8];
      assign hi_word[8*(BYTES-1-2*i) +: 8] = opnd_b[8*i +: 8];
      assign lo_word[8*(2*i) +: 8]         = opnd_a[8*i +: 8];
      assign lo_word[8*(BYTES-1-2*i) +: 8] = opnd_b[8*(HALF_BYTES+i) +: 8];
   end

endmodule

// File: rtl/hdig_key_window.sv
module hdig_key_window
   import hdig_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   input  logic [OPND_W-1:0] key,
   input  logic [GRP_W-1:0]  grp,
   output kwin_t             win
);
   kwin_t win_q;
   kwin_t init_w;

   for (genvar j = 0; j < KEY_WORDS; j++) begin : g_init
      assign init_w[j] = key[OPND_W-1-HALF_W*j -: HALF_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (load) begin
         win_q <= init_w;
      end else if (adv) begin
         win_q <= kwin_next(win_q, grp);
      end
   end

   assign win = win_q;

   // the schedule has only NUM_GROUPS groups; the last one is never advanced
   assert_no_adv_past_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> (grp != GRP_W'(NUM_GROUPS - 1)));

   assert_load_adv_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && adv));

endmodule

// File: rtl/hdig_round_chain.sv
module hdig_round_chain
   import hdig_pkg::*;
#(
   parameter int unsigned DEPTH = 1
)(
   input  word_t      cur,
   input  kwin_t      win,
   input  logic [1:0] sub,
   input  logic [1:0] lane,
   output word_t      nxt
);
   word_t [DEPTH:0] stage;

   assign stage[0] = cur;

   for (genvar u = 0; u < DEPTH; u++) begin : g_rnd
      logic [1:0] sel;
      half_t      lft;
      half_t      rgt;
      assign sel = 2'(sub + lane + 2'(u));
      assign lft = stage[u][HALF_W-1:0];
      assign rgt = stage[u][WORD_W-1:HALF_W];
      assign stage[u+1] = {lft, rgt ^ mix_f(lft) ^ win[sel]};
   end

   assign nxt = stage[DEPTH];

endmodule

// File: rtl/hdig_digest_unit.sv
module hdig_digest_unit
   import hdig_pkg::*;
#(
   parameter int unsigned PARALLEL_LANES   = 4,
   parameter int unsigned ROUNDS_PER_CYCLE = 1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [63:0] req_a,
   input  logic [63:0] req_b,
   input  logic [63:0] req_key,
   output logic        res_valid,
   input  logic        res_ack,
   output logic [63:0] res_digest
);
   localparam int unsigned STEPS   = NUM_ROUNDS / ROUNDS_PER_CYCLE;
   localparam int unsigned PASSES  = NUM_LANES / PARALLEL_LANES;
   localparam int unsigned LATENCY = STEPS * PASSES;
   localparam int unsigned RND_W   = $clog2(NUM_ROUNDS);
   localparam int unsigned LAT_W   = $clog2(LATENCY + 1) + 1;
   localparam logic [RND_W-1:0] RND_LAST = RND_W'(NUM_ROUNDS - ROUNDS_PER_CYCLE);
   localparam logic [RND_W-1:0] RND_INC  = RND_W'(ROUNDS_PER_CYCLE);
   localparam logic [1:0]       SUB_INC  = 2'(ROUNDS_PER_CYCLE % KEY_WORDS);

   if (!(PARALLEL_LANES == 1 || PARALLEL_LANES == NUM_LANES)) begin : g_bad_lanes
      $error("hdig_digest_unit: PARALLEL_LANES must be 1 or 4");
   end
   if (!(ROUNDS_PER_CYCLE == 1 || ROUNDS_PER_CYCLE == 2 || ROUNDS_PER_CYCLE == 4))
   begin : g_bad_rpc
      $error("hdig_digest_unit: ROUNDS_PER_CYCLE must be 1, 2 or 4");
   end

   state_t              state_q;
   logic [RND_W-1:0]    rnd_q;
   logic [OPND_W-1:0]   dig_q;
   logic [OPND_W-1:0]   h_in;
   logic [OPND_W-1:0]   l_in;
   logic [OPND_W-1:0]   key_src;
   logic [OPND_W-1:0]   fin_word;
   kwin_t               win;
   logic                accept;
   logic                running;
   logic                last_step;
   logic                grp_end;
   logic                final_pass;
   logic                key_load;
   logic                key_adv;

   assign req_ready  = (state_q == ST_IDLE);
   assign res_valid  = (state_q == ST_DONE);
   assign res_digest = dig_q;
   assign accept     = req_valid && req_ready;
   assign running    = (state_q == ST_RUN);
   assign last_step  = (rnd_q == RND_LAST);
   assign grp_end    = (2'(rnd_q[1:0] + SUB_INC) == 2'd0);
   assign key_adv    = running && grp_end && !last_step;

   hdig_byte_interleave #(.BYTES(OPND_W / 8)) u_ilv (
      .opnd_a  (req_a),
      .opnd_b  (req_b),
      .hi_word (h_in),
      .lo_word (l_in)
   );

   hdig_key_window u_kwin (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (key_load),
      .adv   (key_adv),
      .key   (key_src),
      .grp   (rnd_q[RND_W-1:2]),
      .win   (win)
   );

   if (PARALLEL_LANES == NUM_LANES) begin : g_par
      word_t [NUM_LANES-1:0] st_q;
      word_t [NUM_LANES-1:0] st_nxt;
      word_t [NUM_LANES-1:0] src;

      // quarter n enters lane n
      assign src = {l_in[WORD_W-1:0], l_in[OPND_W-1:WORD_W],
                    h_in[WORD_W-1:0], h_in[OPND_W-1:WORD_W]};

      for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
         hdig_round_chain #(.DEPTH(ROUNDS_PER_CYCLE)) u_chain (
            .cur  (st_q[ln]),
            .win  (win),
            .sub  (rnd_q[1:0]),
            .lane (2'(ln)),
            .nxt  (st_nxt[ln])
         );
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q <= '0;
         end else if (accept) begin
            st_q <= src;
         end else if (running) begin
            st_q <= st_nxt;
         end
      end

      assign final_pass = 1'b1;
      assign key_load   = accept;
      assign key_src    = req_key;
      assign fin_word   = {st_nxt[0] ^ st_nxt[2], st_nxt[1] ^ st_nxt[3]};

   end else begin : g_ser
      word_t             st_q;
      word_t             st_nxt;
      word_t             reload;
      word_t             hi_q;
      word_t             lo_q;
      logic [1:0]        lane_q;
      logic [1:0]        lane_nx;
      logic [OPND_W-1:0] h_q;
      logic [OPND_W-1:0] l_q;
      logic [OPND_W-1:0] key_q;

      hdig_round_chain #(.DEPTH(ROUNDS_PER_CYCLE)) u_chain (
         .cur  (st_q),
         .win  (win),
         .sub  (rnd_q[1:0]),
         .lane (lane_q),
         .nxt  (st_nxt)
      );

      assign lane_nx = 2'(lane_q + 2'd1);

      always_comb begin
         unique case (lane_nx)
            2'd1:    reload = h_q[WORD_W-1:0];
            2'd2:    reload = l_q[OPND_W-1:WORD_W];
            2'd3:    reload = l_q[WORD_W-1:0];
            default: reload = h_q[OPND_W-1:WORD_W];
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q   <= '0;
            lane_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            h_q    <= '0;
            l_q    <= '0;
            key_q  <= '0;
         end else if (accept) begin
            st_q   <= h_in[OPND_W-1:WORD_W];
            lane_q <= '0;
            h_q    <= h_in;
            l_q    <= l_in;
            key_q  <= req_key;
         end else if (running) begin
            if (last_step) begin
               st_q   <= reload;
               lane_q <= lane_nx;
               unique case (lane_q)
                  2'd0:    hi_q <= st_nxt;
                  2'd1:    lo_q <= st_nxt;
                  2'd2:    hi_q <= hi_q ^ st_nxt;
                  default: ;
               endcase
            end else begin
               st_q <= st_nxt;
            end
         end
      end

      assign final_pass = (lane_q == 2'd3);
      assign key_load   = accept || (running && last_step && !final_pass);
      assign key_src    = accept ? req_key : key_q;
      assign fin_word   = {hi_q, lo_q ^ st_nxt};

      // a lane pass is never cut short
      assert_lane_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
         running && !last_step |=> $stable(lane_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rnd_q   <= '0;
         dig_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q <= ST_RUN;
                  rnd_q   <= '0;
               end
            end
            ST_RUN: begin
               rnd_q <= last_step ? '0 : RND_W'(rnd_q + RND_INC);
               if (last_step && final_pass) begin
                  state_q <= ST_DONE;
                  dig_q   <= fin_word;
               end
            end
            ST_DONE: begin
               if (res_ack) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // cycle counter used only by the latency assertion
   logic [LAT_W-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lat_q <= '0;
      else if (accept)  lat_q <= '0;
      else if (running) lat_q <= LAT_W'(lat_q + 1'b1);
   end

   assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_valid) |-> (lat_q == LAT_W'(LATENCY)));

   assert_accept_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready && !res_valid);

   assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !res_ack |=> res_valid && $stable(res_digest));

   assert_ack_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_ack |=> req_ready && !res_valid);

   assert_round_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (rnd_q % RND_INC) == '0);

endmodule

// File: tb/hdig_digest_unit_tb.sv
`timescale 1ns/1ps
module hdig_digest_unit_tb_top;

   localparam int unsigned TB_LANES = 4;
   localparam int unsigned TB_RPC   = 1;
   localparam int          EXP_LAT  = (32 / TB_RPC) * (4 / TB_LANES);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_a = '0;
   logic [63:0] req_b = '0;
   logic [63:0] req_key = '0;
   logic        res_valid;
   logic        res_ack = 1'b0;
   logic [63:0] res_digest;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   hdig_digest_unit #(
      .PARALLEL_LANES   (TB_LANES),
      .ROUNDS_PER_CYCLE (TB_RPC)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_a      (req_a),
      .req_b      (req_b),
      .req_key    (req_key),
      .res_valid  (res_valid),
      .res_ack    (res_ack),
      .res_digest (res_digest)
   );

   // ---------------- reference model ----------------
   function automatic logic [15:0] m_rol(input logic [15:0] v, input int n);
      return 16'((v << n) | (v >> (16 - n)));
   endfunction

   function automatic logic [15:0] m_ror(input logic [15:0] v, input int n);
      return 16'((v >> n) | (v << (16 - n)));
   endfunction

   function automatic logic [31:0] m_enc(input logic [31:0] x, input logic [63:0] key,
                                         input int lane);
      logic [63:0] zseq;
      logic [15:0] k [32];
      logic [15:0] lo, hi, t, nl, ek;
      zseq = 64'hFA2561CDF44AC398;
      k[0] = key[63:48];
      k[1] = key[47:32];
      k[2] = key[31:16];
      k[3] = key[15:0];
      for (int i = 0; i < 28; i++) begin
         t = m_ror(k[i+3], 3) ^ k[i+1];
         k[i+4] = 16'hFFFC ^ {15'd0, zseq[63-i]} ^ k[i] ^ t ^ m_ror(t, 1);
      end
      lo = x[15:0];
      hi = x[31:16];
      for (int j = 0; j < 32; j++) begin
         ek = k[4*(j/4) + ((j + lane) % 4)];
         nl = hi ^ ((m_rol(lo, 1) & m_rol(lo, 8)) ^ m_rol(lo, 2)) ^ ek;
         hi = lo;
         lo = nl;
      end
      return {hi, lo};
   endfunction

   function automatic logic [63:0] m_digest(input logic [63:0] a, input logic [63:0] b,
                                            input logic [63:0] key);
      logic [63:0] h, l, hp, lp;
      for (int i = 0; i < 4; i++) begin
         h[8*(2*i) +: 8]   = a[8*(4+i) +: 8];
         h[8*(7-2*i) +: 8] = b[8*i +: 8];
         l[8*(2*i) +: 8]   = a[8*i +: 8];
         l[8*(7-2*i) +: 8] = b[8*(4+i) +: 8];
      end
      hp = {m_enc(h[63:32], key, 0), m_enc(h[31:0], key, 1)};
      lp = {m_enc(l[63:32], key, 2), m_enc(l[31:0], key, 3)};
      return hp ^ lp;
   endfunction

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // offers a request, returns at the first falling edge after acceptance
   task automatic send_req(input logic [63:0] a, input logic [63:0] b,
                           input logic [63:0] k);
      @(negedge clk);
      req_valid = 1'b1;
      req_a = a;
      req_b = b;
      req_key = k;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      req_a = ~a ^ 64'h5A5A_0F0F_3C3C_9696;
      req_b = {b[31:0], b[63:32]} ^ 64'h1;
      req_key = ~k;
   endtask

   task automatic wait_res(output int lat);
      lat = 0;
      while (!res_valid && lat < 1000) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic full_req(input logic [63:0] a, input logic [63:0] b,
                           input logic [63:0] k, input string req);
      int lat;
      logic [63:0] exp;
      exp = m_digest(a, b, k);
      send_req(a, b, k);
      chk(!req_ready, "R7", "ready low after accept", 64'(req_ready), 64'd0);
      wait_res(lat);
      chk(lat == EXP_LAT, "R10", "latency", 64'(lat), 64'(EXP_LAT));
      chk(res_digest == exp, req, "digest", res_digest, exp);
      res_ack = 1'b1;
      @(negedge clk);
      res_ack = 1'b0;
      chk(req_ready && !res_valid, "R11", "ready/valid after ack",
          {62'd0, req_ready, res_valid}, 64'd2);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
      chk(res_valid == 1'b0, "R1", "res_valid", 64'(res_valid), 64'd0);
      chk(res_digest == '0, "R1", "res_digest", res_digest, 64'd0);
   endtask

   task automatic t_vectors();
      full_req(64'd0, 64'd0, 64'd0, "R4 R5 R6 zeros");
      full_req('1, '1, '1, "R4 R5 R6 ones");
      full_req(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
               64'h0F1E_2D3C_4B5A_6978, "R4 R5 R6 pattern");
      full_req(64'h0, 64'h0, 64'h8000_0000_0000_0001, "R4 key edges");
      // identical halves: H equals L, only the lane rotation tells them apart
      full_req(64'hDEAD_BEEF_DEAD_BEEF, 64'h1357_9BDF_1357_9BDF,
               64'hC001_D00D_0BAD_F00D, "R6 equal quarters");
   endtask

   task automatic t_byte_walk();
      for (int n = 0; n < 8; n++) begin
         full_req(64'hA5 << (8*n), 64'd0, 64'h1122_3344_5566_7788, "R2 R3 A byte");
         full_req(64'd0, 64'h3C << (8*n), 64'h1122_3344_5566_7788, "R2 R3 B byte");
      end
   endtask

   task automatic t_capture();
      // send_req scrambles the inputs right after acceptance
      full_req(64'h7777_0000_1111_FFFF, 64'h0000_AAAA_5555_0000,
               64'h2468_ACE0_1357_9BDF, "R9 capture");
   endtask

   task automatic t_hold();
      int lat;
      bit hold_ok = 1'b1;
      logic [63:0] d0, a2, b2, k2;
      a2 = 64'hCAFE_F00D_1234_5678;
      b2 = 64'h8765_4321_0BAD_BEEF;
      k2 = 64'h0001_0002_0003_0004;
      send_req(64'h1, 64'h2, 64'h3);
      wait_res(lat);
      chk(res_digest == m_digest(64'h1, 64'h2, 64'h3), "R6", "first digest",
          res_digest, m_digest(64'h1, 64'h2, 64'h3));
      d0 = res_digest;
      req_valid = 1'b1;
      req_a = a2;
      req_b = b2;
      req_key = k2;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (!res_valid || res_digest != d0 || req_ready) hold_ok = 1'b0;
      end
      chk(hold_ok, "R8", "result frozen while unacknowledged", res_digest, d0);
      res_ack = 1'b1;
      @(negedge clk);
      res_ack = 1'b0;
      chk(req_ready && !res_valid, "R11", "release with request pending",
          {62'd0, req_ready, res_valid}, 64'd2);
      @(negedge clk);
      chk(!req_ready, "R7", "pending request accepted", 64'(req_ready), 64'd0);
      req_valid = 1'b0;
      wait_res(lat);
      chk(lat == EXP_LAT, "R10", "latency after back-to-back", 64'(lat), 64'(EXP_LAT));
      chk(res_digest == m_digest(a2, b2, k2), "R7", "digest of waiting request",
          res_digest, m_digest(a2, b2, k2));
      res_ack = 1'b1;
      @(negedge clk);
      res_ack = 1'b0;
   endtask

   initial begin
      #1_000_000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_vectors();
      t_byte_walk();
      t_capture();
      t_hold();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule